// File: doc/BRIEF.md
# Shift Rotate Unit With Carry

A 32-bit combinational shifter for an integer execution pipe. One operation select picks a logical shift left or right by a register amount, an arithmetic shift right by a register amount or by a 5-bit immediate, a rotate-left-then-mask, or a rotate-left-then-insert that merges the masked rotated value into the previous destination value. Arithmetic shifts also produce a carry flag. The carry is set only when the source is negative and at least one 1 bit was shifted out.

Register-supplied amounts are six bits wide. When bit 5 is set, the shift saturates instead of wrapping modulo 32. The immediate arithmetic shift and both rotate forms use only the low five bits of the amount. The rotate mask is given as a begin and an end position in big-endian bit numbering, where position 0 is the most significant bit. The mask wraps around when the begin position is greater than the end position. The flag register and any condition recording belong to the caller.

Top module: `shiftRotUnit`

## Requirements
- R1: With opSel = 0 (shift left, register amount), result is 0 when shAmt[5] = 1; otherwise result is srcVal shifted left by shAmt[4:0], zero filled.
- R2: With opSel = 1 (shift right, register amount), result is 0 when shAmt[5] = 1; otherwise result is srcVal shifted right by shAmt[4:0], zero filled.
- R3: With opSel = 2 (arithmetic right, register amount) and shAmt[5] = 0, result is srcVal shifted right by shAmt[4:0] with sign fill. carryOut is 1 exactly when srcVal[31] = 1 and a 1 bit was shifted out, so an amount of 0 gives carryOut = 0.
- R4: With opSel = 2 and shAmt[5] = 1, result is all ones for a negative srcVal and 0 otherwise. carryOut is 1 only when srcVal[31] = 1 and srcVal[30:0] is nonzero.
- R5: With opSel = 3 (arithmetic right, immediate), shAmt[5] is ignored and the shift uses shAmt[4:0] with the carry rule of R3. An amount of 0 returns srcVal unchanged with carryOut = 0.
- R6: With opSel = 4 (rotate and mask), result is srcVal rotated left by shAmt[4:0], ANDed with the mask. shAmt[5] is ignored.
- R7: Mask bit at big-endian position p (little-endian bit 31-p) is 1 when maskBegin <= p <= maskEnd if maskBegin <= maskEnd, and when p >= maskBegin or p <= maskEnd otherwise.
- R8: With opSel = 5 (rotate and insert), result is (rotated AND mask) OR (oldDest AND NOT mask), using the rotation of R6.
- R9: carryOut is 0 for every opSel other than 2 and 3.
- R10: opSel values 6 and 7 are reserved and give result 0 and carryOut 0.
- R11: The unit has no state. result and carryOut follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcVal | input | 32 | Source operand |
| shAmt | input | 6 | Shift or rotate amount; bit 5 is used only by register shifts |
| maskBegin | input | 5 | First mask position, big-endian numbering |
| maskEnd | input | 5 | Last mask position, big-endian numbering |
| oldDest | input | 32 | Previous destination value for the insert form |
| opSel | input | 3 | Operation select (0..5, 6 and 7 reserved) |
| result | output | 32 | Operation result |
| carryOut | output | 1 | Carry from arithmetic right shifts |

## Verification
The unit has no state, so every result and carry is due in the same cycle that the inputs are applied. The bench drives each input set on a falling clock edge and samples result and carryOut one nanosecond later, well before the next rising edge. A stale or registered value therefore shows up as a mismatch. There are no further cycles of latency to count.

// File: rtl/shiftRotPkg.sv
package shiftRotPkg;

  typedef enum logic [2:0] {
    OP_SHL      = 3'd0,
    OP_SHR      = 3'd1,
    OP_SRA_VAR  = 3'd2,
    OP_SRA_IMM  = 3'd3,
    OP_ROT_MASK = 3'd4,
    OP_ROT_INS  = 3'd5
  } srOp_e;

  typedef struct packed {
    logic satEnable;
    logic shLeft;
    logic shRight;
    logic arith;
    logic rotate;
    logic insert;
  } srCtrl_t;

endpackage

// File: rtl/shiftRotCtrl.sv
module shiftRotCtrl
  import shiftRotPkg::*;
(
  input  logic [2:0] opSel,
  output srCtrl_t    ctrl
);
  always_comb begin
    ctrl = '0;
    case (opSel)
      OP_SHL:      begin ctrl.shLeft = 1'b1;  ctrl.satEnable = 1'b1; end
      OP_SHR:      begin ctrl.shRight = 1'b1; ctrl.satEnable = 1'b1; end
      OP_SRA_VAR:  begin ctrl.shRight = 1'b1; ctrl.arith = 1'b1; ctrl.satEnable = 1'b1; end
      OP_SRA_IMM:  begin ctrl.shRight = 1'b1; ctrl.arith = 1'b1; end
      OP_ROT_MASK: ctrl.rotate = 1'b1;
      OP_ROT_INS:  begin ctrl.rotate = 1'b1; ctrl.insert = 1'b1; end
      default:     ctrl = '0;
    endcase
  end
endmodule

// File: rtl/shiftRotMaskGen.sv
module shiftRotMaskGen #(
  parameter int DataW = 32,
  parameter int AmtW  = $clog2(DataW)
) (
  input  logic [AmtW-1:0]  maskBegin,
  input  logic [AmtW-1:0]  maskEnd,
  output logic [DataW-1:0] mask
);
  logic noWrap;
  assign noWrap = (maskBegin <= maskEnd);

  for (genvar j = 0; j < DataW; j++) begin : g_bit
    // position counted from the most significant bit
    localparam logic [AmtW-1:0] BePos = AmtW'(DataW - 1 - j);
    logic geBegin, leEnd;
    assign geBegin = (BePos >= maskBegin);
    assign leEnd   = (BePos <= maskEnd);
    assign mask[j] = noWrap ? (geBegin & leEnd) : (geBegin | leEnd);
  end
endmodule

// File: rtl/shiftRotDatapath.sv
module shiftRotDatapath
  import shiftRotPkg::*;
#(
  parameter int DataW = 32,
  parameter int AmtW  = $clog2(DataW)
) (
  input  srCtrl_t          ctrl,
  input  logic [DataW-1:0] srcVal,
  input  logic [AmtW:0]    shAmt,
  input  logic [DataW-1:0] oldDest,
  input  logic [DataW-1:0] mask,
  output logic [DataW-1:0] result,
  output logic             carryOut
);
  localparam int DblW = 2 * DataW;

  logic [AmtW-1:0]  amt;
  logic             overRange;
  logic             srcNeg;
  logic             restNonZero;
  logic [DataW-1:0] sllVal, srlVal, sraVal, lostMask, rotVal, rotMasked;
  logic             lostOnes;
  logic [DblW-1:0]  dblVal;

  assign amt         = shAmt[AmtW-1:0];
  assign overRange   = ctrl.satEnable & shAmt[AmtW];
  assign srcNeg      = srcVal[DataW-1];
  assign restNonZero = |srcVal[DataW-2:0];

  assign sllVal   = srcVal << amt;
  assign srlVal   = srcVal >> amt;
  assign sraVal   = $signed(srcVal) >>> amt;
  assign lostMask = ~({DataW{1'b1}} << amt);
  assign lostOnes = |(srcVal & lostMask);

  assign dblVal    = {srcVal, srcVal} << amt;
  assign rotVal    = dblVal[DblW-1:DataW];
  assign rotMasked = rotVal & mask;

  always_comb begin
    result   = '0;
    carryOut = 1'b0;
    if (ctrl.shLeft) begin
      result = overRange ? '0 : sllVal;
    end else if (ctrl.shRight && !ctrl.arith) begin
      result = overRange ? '0 : srlVal;
    end else if (ctrl.arith) begin
      if (overRange) begin
        result   = {DataW{srcNeg}};
        carryOut = srcNeg & restNonZero;
      end else begin
        result   = sraVal;
        carryOut = srcNeg & lostOnes;
      end
    end else if (ctrl.rotate) begin
      result = ctrl.insert ? (rotMasked | (oldDest & ~mask)) : rotMasked;
    end
  end
endmodule

// File: rtl/shiftRotUnit.sv
module shiftRotUnit
  import shiftRotPkg::*;
#(
  parameter int DataW = 32,
  parameter int AmtW  = $clog2(DataW)
) (
  input  logic [DataW-1:0] srcVal,
  input  logic [AmtW:0]    shAmt,
  input  logic [AmtW-1:0]  maskBegin,
  input  logic [AmtW-1:0]  maskEnd,
  input  logic [DataW-1:0] oldDest,
  input  logic [2:0]       opSel,
  output logic [DataW-1:0] result,
  output logic             carryOut
);
  srCtrl_t          ctrl;
  logic [DataW-1:0] mask;

  shiftRotCtrl ctrl_i (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  shiftRotMaskGen #(.DataW(DataW), .AmtW(AmtW)) mask_i (
    .maskBegin (maskBegin),
    .maskEnd   (maskEnd),
    .mask      (mask)
  );

  shiftRotDatapath #(.DataW(DataW), .AmtW(AmtW)) dp_i (
    .ctrl     (ctrl),
    .srcVal   (srcVal),
    .shAmt    (shAmt),
    .oldDest  (oldDest),
    .mask     (mask),
    .result   (result),
    .carryOut (carryOut)
  );
endmodule

// File: rtl/shiftRotUnitChk.sv
module shiftRotUnitChk #(
  parameter int DataW = 32,
  parameter int AmtW  = $clog2(DataW)
) (
  input logic [DataW-1:0] srcVal,
  input logic [AmtW:0]    shAmt,
  input logic [AmtW-1:0]  maskBegin,
  input logic [AmtW-1:0]  maskEnd,
  input logic [DataW-1:0] oldDest,
  input logic [2:0]       opSel,
  input logic [DataW-1:0] result,
  input logic             carryOut
);
  always_comb begin
    // R1: saturated left shift clears the result
    p_shl_sat_r1: assert (!(opSel == 3'd0 && shAmt[AmtW]) || result == '0);
    // R2: saturated right shift clears the result
    p_shr_sat_r2: assert (!(opSel == 3'd1 && shAmt[AmtW]) || result == '0);
    // R3: a non-negative source never produces a carry
    p_pos_nocarry_r3: assert (!((opSel == 3'd2 || opSel == 3'd3) && !srcVal[DataW-1]) || !carryOut);
    // R4: saturated arithmetic shift is pure sign fill
    p_sra_sat_r4: assert (!(opSel == 3'd2 && shAmt[AmtW]) || result == {DataW{srcVal[DataW-1]}});
    // R5: immediate shift by zero passes through
    p_imm_zero_r5: assert (!(opSel == 3'd3 && shAmt[AmtW-1:0] == '0) || (result == srcVal && !carryOut));
    // R8: with an empty-looking full mask the old value does not leak in
    p_ins_full_r8: assert (!(opSel == 3'd5 && maskBegin == '0 && maskEnd == '1 && shAmt[AmtW-1:0] == '0) || result == srcVal);
    // R9: only arithmetic shifts raise the carry
    p_carry_only_sra_r9: assert ((opSel == 3'd2 || opSel == 3'd3) || !carryOut);
    // R10: reserved codes yield zero
    p_reserved_r10: assert (!(opSel >= 3'd6) || (result == '0 && !carryOut));
  end
endmodule

bind shiftRotUnit shiftRotUnitChk #(.DataW(DataW), .AmtW(AmtW)) chk_i (
  .srcVal    (srcVal),
  .shAmt     (shAmt),
  .maskBegin (maskBegin),
  .maskEnd   (maskEnd),
  .oldDest   (oldDest),
  .opSel     (opSel),
  .result    (result),
  .carryOut  (carryOut)
);

// File: tb/shiftRotUnit_tb_top.sv
module shiftRotUnit_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic [31:0] srcVal, oldDest, result;
  logic [5:0]  shAmt;
  logic [4:0]  maskBegin, maskEnd;
  logic [2:0]  opSel;
  logic        carryOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  shiftRotUnit dut_i (
    .srcVal(srcVal), .shAmt(shAmt), .maskBegin(maskBegin), .maskEnd(maskEnd),
    .oldDest(oldDest), .opSel(opSel), .result(result), .carryOut(carryOut)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] src;
    logic [5:0]  amt;
    logic [4:0]  mb;
    logic [4:0]  me;
    logic [31:0] old;
    logic [31:0] res;
    logic        car;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h0000_00F1, 6'd4,     5'd0,  5'd0,  32'h0, 32'h0000_0F10, 1'b0, 8'd1},  // R1
    '{3'd0, 32'h8000_0001, 6'd31,    5'd0,  5'd0,  32'h0, 32'h8000_0000, 1'b0, 8'd1},  // R1
    '{3'd0, 32'hFFFF_FFFF, 6'h20,    5'd0,  5'd0,  32'h0, 32'h0,         1'b0, 8'd1},  // R1
    '{3'd0, 32'hFFFF_FFFF, 6'h25,    5'd0,  5'd0,  32'h0, 32'h0,         1'b0, 8'd1},  // R1
    '{3'd1, 32'h8000_0000, 6'd31,    5'd0,  5'd0,  32'h0, 32'h0000_0001, 1'b0, 8'd2},  // R2
    '{3'd1, 32'hF000_000F, 6'd4,     5'd0,  5'd0,  32'h0, 32'h0F00_0000, 1'b0, 8'd2},  // R2
    '{3'd1, 32'hFFFF_FFFF, 6'h3F,    5'd0,  5'd0,  32'h0, 32'h0,         1'b0, 8'd2},  // R2
    '{3'd2, 32'h8000_0010, 6'd4,     5'd0,  5'd0,  32'h0, 32'hF800_0001, 1'b0, 8'd3},  // R3
    '{3'd2, 32'h8000_0018, 6'd4,     5'd0,  5'd0,  32'h0, 32'hF800_0001, 1'b1, 8'd3},  // R3
    '{3'd2, 32'h7000_00FF, 6'd8,     5'd0,  5'd0,  32'h0, 32'h0070_0000, 1'b0, 8'd3},  // R3
    '{3'd2, 32'h8000_0001, 6'd0,     5'd0,  5'd0,  32'h0, 32'h8000_0001, 1'b0, 8'd3},  // R3
    '{3'd2, 32'h8000_0000, 6'h20,    5'd0,  5'd0,  32'h0, 32'hFFFF_FFFF, 1'b0, 8'd4},  // R4
    '{3'd2, 32'h8000_0004, 6'h3A,    5'd0,  5'd0,  32'h0, 32'hFFFF_FFFF, 1'b1, 8'd4},  // R4
    '{3'd2, 32'h7FFF_FFFF, 6'h21,    5'd0,  5'd0,  32'h0, 32'h0,         1'b0, 8'd4},  // R4
    '{3'd3, 32'h8000_0003, 6'd0,     5'd0,  5'd0,  32'h0, 32'h8000_0003, 1'b0, 8'd5},  // R5
    '{3'd3, 32'h8000_0003, 6'h21,    5'd0,  5'd0,  32'h0, 32'hC000_0001, 1'b1, 8'd5},  // R5
    '{3'd3, 32'hFFFF_FFFF, 6'd31,    5'd0,  5'd0,  32'h0, 32'hFFFF_FFFF, 1'b1, 8'd5},  // R5
    '{3'd4, 32'h1234_5678, 6'd8,     5'd0,  5'd31, 32'h0, 32'h3456_7812, 1'b0, 8'd6},  // R6
    '{3'd4, 32'h1234_5678, 6'h28,    5'd24, 5'd31, 32'h0, 32'h0000_0012, 1'b0, 8'd6},  // R6
    '{3'd4, 32'hFFFF_FFFF, 6'd0,     5'd28, 5'd3,  32'h0, 32'hF000_000F, 1'b0, 8'd7},  // R7
    '{3'd4, 32'hFFFF_FFFF, 6'd0,     5'd5,  5'd5,  32'h0, 32'h0400_0000, 1'b0, 8'd7},  // R7
    '{3'd4, 32'h8000_0000, 6'd1,     5'd31, 5'd31, 32'h0, 32'h0000_0001, 1'b0, 8'd7},  // R7
    '{3'd5, 32'h0000_00AB, 6'd16,    5'd8,  5'd15, 32'hFFFF_FFFF, 32'hFFAB_FFFF, 1'b0, 8'd8}, // R8
    '{3'd5, 32'h0000_0001, 6'd0,     5'd0,  5'd31, 32'h5555_5555, 32'h0000_0001, 1'b0, 8'd8}, // R8
    '{3'd5, 32'hA5A5_0000, 6'd4,     5'd16, 5'd15, 32'h0, 32'h5A50_000A, 1'b0, 8'd8},  // R8
    '{3'd6, 32'hFFFF_FFFF, 6'd3,     5'd0,  5'd31, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'd10}, // R10
    '{3'd7, 32'hFFFF_FFFF, 6'd3,     5'd0,  5'd31, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'd10}  // R10
  };

  task automatic applyIn(input logic [2:0] op, input logic [31:0] src, input logic [5:0] amt,
                         input logic [4:0] mb, input logic [4:0] me, input logic [31:0] old);
    @(negedge clk);
    opSel = op; srcVal = src; shAmt = amt; maskBegin = mb; maskEnd = me; oldDest = old;
    #1;
  endtask

  task automatic checkOut(input string tag, input logic [31:0] expRes, input logic expCar);
    compared++;
    if (result !== expRes || carryOut !== expCar) begin
      mismatched++;
      $display("FAIL %s: result=%08h carry=%0b expected result=%08h carry=%0b",
               tag, result, carryOut, expRes, expCar);
    end
  endtask

  initial begin
    opSel = 3'd0; srcVal = '0; shAmt = '0; maskBegin = '0; maskEnd = '0; oldDest = '0;
    // R11: idle inputs give a quiet output with no clocking history
    applyIn(3'd0, 32'h0, 6'd0, 5'd0, 5'd0, 32'h0);
    checkOut("R11 idle", 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      applyIn(VECS[i].op, VECS[i].src, VECS[i].amt, VECS[i].mb, VECS[i].me, VECS[i].old);
      checkOut($sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].res, VECS[i].car);
    end

    // R9: logical shifts that drop ones from a negative source keep carry low
    applyIn(3'd1, 32'h8000_000F, 6'd4, 5'd0, 5'd0, 32'h0);
    checkOut("R9 srl carry", 32'h0800_0000, 1'b0);
    applyIn(3'd4, 32'h8000_000F, 6'd4, 5'd0, 5'd31, 32'h0);
    checkOut("R9 rot carry", 32'h0000_00F8, 1'b0);

    // R5 sweep: most negative value shifted by every immediate amount
    for (int a = 0; a < 32; a++) begin
      applyIn(3'd3, 32'h8000_0000, 6'(a), 5'd0, 5'd0, 32'h0);
      checkOut($sformatf("R5 sweep %0d", a), ~(32'h7FFF_FFFF >> a), 1'b0);
    end

    // R11: back-to-back changes track within the same cycle
    applyIn(3'd0, 32'h1, 6'd1, 5'd0, 5'd0, 32'h0);
    checkOut("R11 step a", 32'h2, 1'b0);
    applyIn(3'd0, 32'h1, 6'd2, 5'd0, 5'd0, 32'h0);
    checkOut("R11 step b", 32'h4, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule